// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. It holds ready instructions in four small pools, one each for integer, floating-point and branch work and one for cancelled instructions that still have to leave the queue. Every cycle it fills up to `TOTAL_W` issue slots. Each slot gets the oldest instruction, by sequence number, among the pools that are still allowed to issue in that cycle. The integer, floating-point and branch pools each have their own per-cycle cap. The cancelled pool has no cap and competes only on age. An instruction in a class pool that carries the cancel flag is thrown away and never takes a slot.

Each pool keeps its entries unordered. A comparison scan over the live entries finds the pool's oldest one. The selector is an unrolled chain of `TOTAL_W` stages. Each stage compares the four pool heads that are left, marks the entry it takes and counts it against its class. The issue slots and the per-cycle issue count (the number of queue entries freed) are registered. An upstream stage writes to the pools through one push lane per pool. An execute-side stall, `issue_en` low, holds all issue.

Top module: `oldest_issue_select`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every slot valid bit is low, every `pool_full` bit is low and `issue_cnt` is zero.
- R2: Push lane p writes pool p, where p=0 is integer, 1 is floating-point, 2 is branch and 3 is cancelled. Lane p uses `push_vld[p]`, `push_flag[p]` and `push_seq[p*SEQ_W +: SEQ_W]`. The entry is stored at the next clock edge. It can appear in a slot at the edge after that and no earlier.
- R3: Each filled slot carries the smallest sequence number among the heads of the pools that are eligible at that stage. Within one cycle, the slot sequence numbers never decrease from slot 0 upward.
- R4: When eligible heads have equal sequence numbers, the lower pool index wins: integer, then floating-point, then branch, then cancelled.
- R5: In one cycle, at most `INT_W` integer, `FP_W` floating-point and `BR_W` branch instructions issue. Once a class reaches its cap, the remaining slots go to the oldest heads of the other pools.
- R6: The cancelled pool has no class cap and may fill every slot in a cycle. `push_flag` has no effect on lane 3.
- R7: An entry of pool 0, 1 or 2 pushed with its flag set never reaches a slot and takes no slot. It is removed at the first clock edge after it is stored, so its pool no longer counts it as occupied.
- R8: Filled slots are packed from slot 0, with at most `TOTAL_W` per cycle, and `issue_cnt` equals the number of filled slots.
- R9: `pool_full[p]` is high exactly when all `DEPTH` entries of pool p are occupied. A push into a full pool is dropped and never issues.
- R10: `slot_cls[2k+1:2k]` gives the pool index of slot k, with the same encoding as R2. `slot_seq[k*SEQ_W +: SEQ_W]` gives its sequence number.
- R11: When `issue_en` is low at an edge, no slot is filled at that edge and the pools keep their uncancelled entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_en | input | 1 | Execute side can accept issue this cycle |
| push_vld | input | 4 | Per-pool push strobe |
| push_seq | input | 4*SEQ_W | Per-pool sequence number of the pushed entry |
| push_flag | input | 4 | Per-pool cancel flag of the pushed entry |
| pool_full | output | 4 | Per-pool full indication |
| slot_vld | output | TOTAL_W | Issue slot filled |
| slot_cls | output | 2*TOTAL_W | Pool index per slot |
| slot_seq | output | TOTAL_W*SEQ_W | Sequence number per slot |
| issue_cnt | output | clog2(TOTAL_W+1) | Slots filled, which is also the number of entries freed |

## Verification
The bench builds the block with `DEPTH`=4, `TOTAL_W`=3, `INT_W`=2, `FP_W`=1 and `BR_W`=1, with 8-bit sequence numbers. The integer cap of two sits below the total of three, so the spill-over into a third slot from another pool becomes visible. Caps of one for floating-point and branch make those classes saturate on their second entry. A depth of four lets a pool fill in a few cycles, which reaches the full-pool drop and the cancel-frees-space case. Directed sequences cover these cases, and a long stream of random pushes and stalls is compared against an age model that is computed arithmetically.

// File: rtl/iss_pkg.sv
package iss_pkg;

    localparam int SEQ_W   = 8;
    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2,
        CLS_SQ  = 2'd3
    } cls_e;

    typedef logic [SEQ_W-1:0] seq_t;

    localparam seq_t SEQ_NONE = '1;

    typedef struct packed {
        logic vld;
        logic flag;
        seq_t seq;
    } ent_t;

    typedef struct packed {
        logic vld;
        cls_e cls;
        seq_t seq;
    } slot_t;

    // Pools with a per-cycle cap; the cancelled pool drains without one.
    function automatic logic has_cap(int p);
        return p != int'(CLS_SQ);
    endfunction

endpackage

// File: rtl/iss_minfind.sv
module iss_minfind
    import iss_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    input  seq_t [N-1:0]     seq_in,
    output logic             hit,
    output logic [IW-1:0]    idx,
    output seq_t             min_seq
);

    // Comparison scan; strict less-than keeps the lowest index on a tie.
    logic [N:0]       h_chain;
    seq_t [N:0]       m_chain;
    logic [N:0][IW-1:0] i_chain;

    assign h_chain[0] = 1'b0;
    assign m_chain[0] = SEQ_NONE;
    assign i_chain[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        logic take;
        assign take         = cand[i] && (!h_chain[i] || (seq_in[i] < m_chain[i]));
        assign h_chain[i+1] = h_chain[i] | cand[i];
        assign m_chain[i+1] = take ? seq_in[i] : m_chain[i];
        assign i_chain[i+1] = take ? IW'(i) : i_chain[i];
    end

    assign hit     = h_chain[N];
    assign idx     = i_chain[N];
    assign min_seq = m_chain[N];

endmodule

// File: rtl/iss_pool.sv
module iss_pool
    import iss_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter bit DROP_FLAGGED = 1'b1,
    parameter int IW           = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_vld,
    input  seq_t                 push_seq,
    input  logic                 push_flag,
    input  logic [DEPTH-1:0]     pop_mask,
    output ent_t [DEPTH-1:0]     ents,
    output logic                 full
);

    ent_t [DEPTH-1:0] ents_q;
    ent_t [DEPTH-1:0] ents_d;
    logic [DEPTH-1:0] vld_vec;
    logic [IW-1:0]    free_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) vld_vec[i] = ents_q[i].vld;
    end

    assign full = &vld_vec;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_vec[i]) free_idx = IW'(i);
        end
    end

    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (pop_mask[i] || (DROP_FLAGGED && ents_q[i].flag)) ents_d[i] = '0;
        end
        if (push_vld && !full) begin
            ents_d[free_idx].vld  = 1'b1;
            ents_d[free_idx].flag = DROP_FLAGGED ? push_flag : 1'b0;
            ents_d[free_idx].seq  = push_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ents_q <= '0;
        else     ents_q <= ents_d;
    end

    assign ents = ents_q;

    // Selector must only take live entries.
    assert_pop_live_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_mask & ~vld_vec) == '0);

    // A full pool gains nothing from a push.
    assert_full_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (push_vld && full) |=> ($countones(vld_vec) <= $countones($past(vld_vec))));

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        assert_flag_drop_R7: assert property (@(posedge clk) disable iff (rst)
            (DROP_FLAGGED && ents_q[i].vld && ents_q[i].flag) |=> !ents_q[i].vld);
    end

endmodule

// File: rtl/iss_select.sv
module iss_select
    import iss_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int TOTAL_W = 1,
    parameter int INT_W   = 1,
    parameter int FP_W    = 1,
    parameter int BR_W    = 1,
    parameter int CNT_W   = $clog2(TOTAL_W + 1)
) (
    input  logic                              issue_en,
    input  ent_t [NUM_CLS-1:0][DEPTH-1:0]     pools,
    output slot_t [TOTAL_W-1:0]               slots,
    output logic [NUM_CLS-1:0][DEPTH-1:0]     pop_mask,
    output logic [CNT_W-1:0]                  issued
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic int cap_of(int p);
        case (p)
            0:       return INT_W;
            1:       return FP_W;
            2:       return BR_W;
            default: return TOTAL_W;
        endcase
    endfunction

    logic [TOTAL_W:0][NUM_CLS-1:0][DEPTH-1:0] tk_chain;
    logic [TOTAL_W:0][NUM_CLS-1:0][CNT_W-1:0] cnt_chain;
    logic [TOTAL_W-1:0]                       found_vec;

    assign tk_chain[0]  = '0;
    assign cnt_chain[0] = '0;

    for (genvar k = 0; k < TOTAL_W; k++) begin : g_stage
        logic [NUM_CLS-1:0]           hit;
        seq_t [NUM_CLS-1:0]           hseq;
        logic [NUM_CLS-1:0][IW-1:0]   hidx;
        logic                         found;
        logic [1:0]                   best_p;
        seq_t                         best_seq;
        logic [NUM_CLS-1:0][DEPTH-1:0] tk_out;
        logic [NUM_CLS-1:0][CNT_W-1:0] cnt_out;

        for (genvar p = 0; p < NUM_CLS; p++) begin : g_pool
            logic [DEPTH-1:0]   cand;
            seq_t [DEPTH-1:0]   sq_vec;

            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    cand[i]   = pools[p][i].vld && !tk_chain[k][p][i]
                                && !(has_cap(p) && pools[p][i].flag);
                    sq_vec[i] = pools[p][i].seq;
                end
            end

            iss_minfind #(.N(DEPTH), .IW(IW)) u_find (
                .cand    (cand),
                .seq_in  (sq_vec),
                .hit     (hit[p]),
                .idx     (hidx[p]),
                .min_seq (hseq[p])
            );
        end

        always_comb begin
            found    = 1'b0;
            best_p   = '0;
            best_seq = SEQ_NONE;
            for (int p = 0; p < NUM_CLS; p++) begin
                if (issue_en && hit[p]
                    && (!has_cap(p) || (int'(cnt_chain[k][p]) < cap_of(p)))
                    && (!found || (hseq[p] < best_seq))) begin
                    found    = 1'b1;
                    best_p   = 2'(p);
                    best_seq = hseq[p];
                end
            end
            tk_out  = tk_chain[k];
            cnt_out = cnt_chain[k];
            if (found) begin
                tk_out[best_p][hidx[best_p]] = 1'b1;
                cnt_out[best_p] = cnt_chain[k][best_p] + CNT_W'(1);
            end
        end

        assign tk_chain[k+1]  = tk_out;
        assign cnt_chain[k+1] = cnt_out;
        assign found_vec[k]   = found;
        assign slots[k]       = '{vld: found, cls: cls_e'(best_p),
                                  seq: found ? best_seq : SEQ_NONE};
    end

    assign pop_mask = tk_chain[TOTAL_W];

    always_comb begin
        issued = '0;
        for (int k = 0; k < TOTAL_W; k++) issued = issued + CNT_W'(found_vec[k]);
    end

endmodule

// File: rtl/oldest_issue_select.sv
module oldest_issue_select
    import iss_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int TOTAL_W = 1,
    parameter int INT_W   = 1,
    parameter int FP_W    = 1,
    parameter int BR_W    = 1,
    parameter int CNT_W   = $clog2(TOTAL_W + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue_en,
    input  logic [NUM_CLS-1:0]            push_vld,
    input  logic [NUM_CLS*SEQ_W-1:0]      push_seq,
    input  logic [NUM_CLS-1:0]            push_flag,
    output logic [NUM_CLS-1:0]            pool_full,
    output logic [TOTAL_W-1:0]            slot_vld,
    output logic [2*TOTAL_W-1:0]          slot_cls,
    output logic [TOTAL_W*SEQ_W-1:0]      slot_seq,
    output logic [CNT_W-1:0]              issue_cnt
);

    ent_t  [NUM_CLS-1:0][DEPTH-1:0] pool_ents;
    logic  [NUM_CLS-1:0][DEPTH-1:0] pop_mask;
    slot_t [TOTAL_W-1:0]            slots_d;
    slot_t [TOTAL_W-1:0]            slots_q;
    logic  [CNT_W-1:0]              cnt_d;
    logic  [CNT_W-1:0]              cnt_q;

    for (genvar p = 0; p < NUM_CLS; p++) begin : g_pool
        iss_pool #(.DEPTH(DEPTH), .DROP_FLAGGED(has_cap(p))) u_pool (
            .clk       (clk),
            .rst       (rst),
            .push_vld  (push_vld[p]),
            .push_seq  (push_seq[p*SEQ_W +: SEQ_W]),
            .push_flag (push_flag[p]),
            .pop_mask  (pop_mask[p]),
            .ents      (pool_ents[p]),
            .full      (pool_full[p])
        );
    end

    iss_select #(
        .DEPTH   (DEPTH),
        .TOTAL_W (TOTAL_W),
        .INT_W   (INT_W),
        .FP_W    (FP_W),
        .BR_W    (BR_W),
        .CNT_W   (CNT_W)
    ) u_select (
        .issue_en (issue_en),
        .pools    (pool_ents),
        .slots    (slots_d),
        .pop_mask (pop_mask),
        .issued   (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            cnt_q   <= '0;
        end else begin
            slots_q <= slots_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        for (int k = 0; k < TOTAL_W; k++) begin
            slot_vld[k]               = slots_q[k].vld;
            slot_cls[2*k +: 2]        = slots_q[k].cls;
            slot_seq[k*SEQ_W +: SEQ_W] = slots_q[k].seq;
        end
    end

    assign issue_cnt = cnt_q;

    function automatic int cls_count(slot_t [TOTAL_W-1:0] s, cls_e c);
        int n = 0;
        for (int k = 0; k < TOTAL_W; k++) if (s[k].vld && s[k].cls == c) n++;
        return n;
    endfunction

    assert_cnt_match_R8: assert property (@(posedge clk) disable iff (rst)
        int'(issue_cnt) == $countones(slot_vld));

    assert_slots_packed_R8: assert property (@(posedge clk) disable iff (rst)
        ((slot_vld + 1'b1) & slot_vld) == '0);

    assert_int_cap_R5: assert property (@(posedge clk) disable iff (rst)
        cls_count(slots_q, CLS_INT) <= INT_W);

    assert_fp_cap_R5: assert property (@(posedge clk) disable iff (rst)
        cls_count(slots_q, CLS_FP) <= FP_W);

    assert_br_cap_R5: assert property (@(posedge clk) disable iff (rst)
        cls_count(slots_q, CLS_BR) <= BR_W);

    assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        !issue_en |=> (slot_vld == '0));

    for (genvar k = 0; k + 1 < TOTAL_W; k++) begin : g_order
        assert_age_order_R3: assert property (@(posedge clk) disable iff (rst)
            slots_q[k+1].vld |-> (slots_q[k].vld && (slots_q[k].seq <= slots_q[k+1].seq)));
    end

endmodule

// File: tb/oldest_issue_select_bench.sv
module oldest_issue_select_bench;

    localparam int DEPTH = 4;
    localparam int TW    = 3;
    localparam int IW_C  = 2;
    localparam int FW_C  = 1;
    localparam int BW_C  = 1;
    localparam int SW    = iss_pkg::SEQ_W;
    localparam int CW    = $clog2(TW + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            issue_en = 1'b0;
    logic [3:0]      push_vld = '0;
    logic [4*SW-1:0] push_seq = '0;
    logic [3:0]      push_flag = '0;
    logic [3:0]      pool_full;
    logic [TW-1:0]   slot_vld;
    logic [2*TW-1:0] slot_cls;
    logic [TW*SW-1:0] slot_seq;
    logic [CW-1:0]   issue_cnt;

    always #10 clk = ~clk;

    oldest_issue_select #(
        .DEPTH(DEPTH), .TOTAL_W(TW), .INT_W(IW_C), .FP_W(FW_C), .BR_W(BW_C)
    ) u_oldest_issue_select (
        .clk(clk), .rst(rst), .issue_en(issue_en),
        .push_vld(push_vld), .push_seq(push_seq), .push_flag(push_flag),
        .pool_full(pool_full), .slot_vld(slot_vld), .slot_cls(slot_cls),
        .slot_seq(slot_seq), .issue_cnt(issue_cnt)
    );

    int nchk = 0;
    int nfail = 0;

    // Age model of the pools.
    bit mv [4][DEPTH];
    bit mf [4][DEPTH];
    int ms [4][DEPTH];
    int ev [TW];
    int ec [TW];
    int es [TW];
    int ecnt;
    bit efull [4];

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int cap_of(int p);
        case (p)
            0: return IW_C;
            1: return FW_C;
            2: return BW_C;
            default: return TW;
        endcase
    endfunction

    task automatic model_step(bit en, bit [3:0] pv, logic [4*SW-1:0] ps, bit [3:0] pf);
        bit tk [4][DEPTH];
        int cnt [4];
        for (int p = 0; p < 4; p++) begin
            cnt[p] = 0;
            for (int i = 0; i < DEPTH; i++) tk[p][i] = 0;
        end
        ecnt = 0;
        for (int k = 0; k < TW; k++) begin
            int best = -1;
            int bseq = 0;
            int bidx = 0;
            ev[k] = 0;
            if (en) begin
                for (int p = 0; p < 4; p++) begin
                    int hi = -1;
                    int hs = 0;
                    for (int i = 0; i < DEPTH; i++) begin
                        if (mv[p][i] && !tk[p][i] && !(p < 3 && mf[p][i])
                            && (hi < 0 || ms[p][i] < hs)) begin
                            hi = i;
                            hs = ms[p][i];
                        end
                    end
                    if (hi >= 0 && (p == 3 || cnt[p] < cap_of(p)) && (best < 0 || hs < bseq)) begin
                        best = p; bseq = hs; bidx = hi;
                    end
                end
            end
            if (best >= 0) begin
                ev[k] = 1; ec[k] = best; es[k] = bseq;
                tk[best][bidx] = 1; cnt[best]++; ecnt++;
            end
        end
        for (int p = 0; p < 4; p++) begin
            bit full_pre = 1;
            int free = -1;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!mv[p][i]) begin full_pre = 0; free = i; end
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (tk[p][i] || (p < 3 && mf[p][i])) begin mv[p][i] = 0; mf[p][i] = 0; end
            end
            if (pv[p] && !full_pre) begin
                mv[p][free] = 1;
                ms[p][free] = int'(ps[p*SW +: SW]);
                mf[p][free] = (p < 3) ? pf[p] : 1'b0;
            end
            efull[p] = 1;
            for (int i = 0; i < DEPTH; i++) if (!mv[p][i]) efull[p] = 0;
        end
    endtask

    task automatic compare();
        for (int k = 0; k < TW; k++) begin
            chk("R8 slot valid", int'(slot_vld[k]), ev[k]);
            if (ev[k] != 0) begin
                chk("R10 slot class", int'(slot_cls[2*k +: 2]), ec[k]);
                chk("R3 slot age", int'(slot_seq[k*SW +: SW]), es[k]);
            end
        end
        chk("R8 issue_cnt", int'(issue_cnt), ecnt);
        for (int p = 0; p < 4; p++) chk("R9 pool_full", int'(pool_full[p]), int'(efull[p]));
    endtask

    task automatic cyc(bit en, bit [3:0] pv, logic [4*SW-1:0] ps, bit [3:0] pf);
        issue_en  = en;
        push_vld  = pv;
        push_seq  = ps;
        push_flag = pf;
        model_step(en, pv, ps, pf);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [4*SW-1:0] lanes(int a, int b, int c, int d);
        return {SW'(d), SW'(c), SW'(b), SW'(a)};
    endfunction

    task automatic slot_is(string tag, int k, int cls, int seq);
        chk(tag, int'(slot_vld[k]), 1);
        chk(tag, int'(slot_cls[2*k +: 2]), cls);
        chk(tag, int'(slot_seq[k*SW +: SW]), seq);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < DEPTH; i++) begin mv[p][i] = 0; mf[p][i] = 0; ms[p][i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 slot_vld", int'(slot_vld), 0);
        chk("R1 pool_full", int'(pool_full), 0);
        chk("R1 issue_cnt", int'(issue_cnt), 0);
        rst = 1'b0;
        cyc(1, 4'b0000, '0, 4'b0000);
        chk("R1 idle after reset", int'(slot_vld), 0);

        // R2: two-edge latency
        cyc(1, 4'b0001, lanes(5, 0, 0, 0), 4'b0000);
        chk("R2 not before second edge", int'(slot_vld), 0);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R2 issued after second edge", 0, 0, 5);
        chk("R2 one slot", int'(slot_vld), 1);

        // R5/R11: integer cap spills into floating-point
        cyc(0, 4'b0111, lanes(10, 13, 15, 0), 4'b0000);
        chk("R11 stalled", int'(slot_vld), 0);
        cyc(0, 4'b0011, lanes(11, 14, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(12, 0, 0, 0), 4'b0000);
        chk("R11 still stalled", int'(slot_vld), 0);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R5 int first", 0, 0, 10);
        slot_is("R5 int second", 1, 0, 11);
        slot_is("R5 int capped, fp next", 2, 1, 13);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R3 oldest int", 0, 0, 12);
        slot_is("R3 then fp", 1, 1, 14);
        slot_is("R3 then br", 2, 2, 15);
        cyc(1, 4'b0000, '0, 4'b0000);
        chk("R8 empty", int'(slot_vld), 0);

        // R5: branch cap
        cyc(0, 4'b0110, lanes(0, 22, 20, 0), 4'b0000);
        cyc(0, 4'b0100, lanes(0, 0, 21, 0), 4'b0000);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R5 br first", 0, 2, 20);
        slot_is("R5 br capped, fp", 1, 1, 22);
        chk("R5 two slots", int'(slot_vld), 3);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R5 br next cycle", 0, 2, 21);

        // R4: equal ages across pools
        cyc(0, 4'b1111, lanes(30, 30, 30, 30), 4'b0000);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R4 tie int", 0, 0, 30);
        slot_is("R4 tie fp", 1, 1, 30);
        slot_is("R4 tie br", 2, 2, 30);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R4 tie cancelled last", 0, 3, 30);

        // R6: cancelled pool uncapped, flag ignored on lane 3
        cyc(0, 4'b1001, lanes(44, 0, 0, 40), 4'b0000);
        cyc(0, 4'b1000, lanes(0, 0, 0, 41), 4'b0000);
        cyc(0, 4'b1000, lanes(0, 0, 0, 42), 4'b0000);
        cyc(0, 4'b1000, lanes(0, 0, 0, 43), 4'b1000);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R6 drain a", 0, 3, 40);
        slot_is("R6 drain b", 1, 3, 41);
        slot_is("R6 drain c", 2, 3, 42);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R6 flagged lane 3 issues", 0, 3, 43);
        slot_is("R6 then int", 1, 0, 44);

        // R7: flagged class entries take no slot
        cyc(1, 4'b0011, lanes(53, 54, 0, 0), 4'b0001);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R7 flagged int skipped", 0, 1, 54);
        chk("R7 single slot", int'(slot_vld), 1);
        cyc(0, 4'b0001, lanes(60, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(61, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(62, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(50, 0, 0, 0), 4'b0001);
        chk("R7 pool full with flagged", int'(pool_full[0]), 1);
        cyc(0, 4'b0000, '0, 4'b0000);
        chk("R7 flagged freed", int'(pool_full[0]), 0);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R7 survivor a", 0, 0, 60);
        slot_is("R7 survivor b", 1, 0, 61);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R7 survivor c", 0, 0, 62);
        chk("R7 flagged never issued", int'(slot_vld), 1);

        // R9: push into full pool dropped
        cyc(0, 4'b0001, lanes(71, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(72, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(73, 0, 0, 0), 4'b0000);
        cyc(0, 4'b0001, lanes(74, 0, 0, 0), 4'b0000);
        chk("R9 full", int'(pool_full[0]), 1);
        cyc(0, 4'b0001, lanes(55, 0, 0, 0), 4'b0000);
        chk("R9 still full", int'(pool_full[0]), 1);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R9 no older intruder", 0, 0, 71);
        slot_is("R9 second", 1, 0, 72);
        cyc(1, 4'b0000, '0, 4'b0000);
        slot_is("R9 third", 0, 0, 73);
        slot_is("R9 fourth", 1, 0, 74);
        cyc(1, 4'b0000, '0, 4'b0000);
        chk("R9 dropped push absent", int'(slot_vld), 0);

        // Random sweep against the age model
        for (int n = 0; n < 3000; n++) begin
            bit [3:0] pv;
            bit [3:0] pf;
            logic [4*SW-1:0] ps;
            for (int p = 0; p < 4; p++) begin
                pv[p] = ($urandom_range(0, 2) != 0);
                pf[p] = ($urandom_range(0, 3) == 0);
                ps[p*SW +: SW] = SW'($urandom_range(0, 255));
            end
            cyc(($urandom_range(0, 3) != 0), pv, ps, pf);
        end

        finish_run();
    end

endmodule